// File: doc/BRIEF.md
# Staggered Four-Channel PWM Generator

The block drives four output ports, each with its own 5-bit duty setting, from one shared timebase. A timing source is chosen between an internal oscillator input and an external clock input. Both inputs are brought into the system clock domain, and the rising edges of the chosen one are counted. Every 32 of those edges advance a 5-bit PWM step counter, so one PWM period lasts 32 steps. With a nominal 32 kHz source, the period is about 32 ms and the step rate is about 1 kHz.

Each port has its own window that is four steps later than the previous port's window, which is one eighth of the period. Because of this, the switching edges of the four ports do not fall on the same step. Each port holds an 8-bit code. A code whose upper nibble is `0111` forces the port high. Any other code uses its low five bits as the duty count. A duty of zero keeps the port low.

A new code takes effect only at the start of that port's own shifted period. An alignment pin, when enabled, clears the whole timebase so that several blocks, or one block and an outside event, can be brought into step.

Each port runs a small state machine with the states CH_LOW (static low), CH_PWM (pulsing) and CH_HIGH (forced high). It leaves its current state only on a load. A load happens either at the port's phase-zero step or while an alignment clear is active. On a load, the next state is decoded from the code: forced-high pattern → CH_HIGH, zero duty → CH_LOW, any other duty → CH_PWM. With no load, the state is held.

Top module: `pwm_stagger_top`

## Requirements
- R1: While `rst_n` is low, all port outputs are 0. After reset, each port stays low until its first load.
- R2: The step counter advances by exactly one (wrapping from 31 to 0) once per 32 rising edges of the selected timing input.
- R3: In pulsing mode, port n is high during the steps where ((count − 4·n) mod 32) < duty. The duty is code bits [4:0], and the period is 32 steps.
- R4: A code whose upper nibble is not `0111` and whose bits [4:0] are 0 keeps the port low for the whole period.
- R5: A code with bits [7:4] = `0111` keeps the port constant high, whatever bits [3:0] hold.
- R6: The windows of ports 0, 1, 2 and 3 start at counts 0, 4, 8 and 12 (one eighth of the period apart), so their rising edges fall on different steps.
- R7: A code change reaches a port only when the counter enters that port's phase-zero step (count = 4·n). A change made earlier in the period has no effect on the output until then.
- R8: `use_ext_i` = 1 selects the external timing input, and 0 (the default) selects the internal one. Edges on the unselected input do not move the counter.
- R9: While `align_en_i` and `align_pin_i` are both 1, the prescaler and counter are held at 0 and every port loads its current code. After release, counting restarts from count 0.
- R10: With `align_en_i` = 0, pulses on `align_pin_i` leave the timebase and the outputs unchanged.
- R11: In a code that is not forced high, bits [7:5] are ignored. For example, `0x81` behaves as duty 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_int_i | input | 1 | Internal oscillator timing input (asynchronous) |
| osc_ext_i | input | 1 | External timing input (asynchronous) |
| use_ext_i | input | 1 | Timing source select: 1 = external, 0 = internal |
| align_pin_i | input | 1 | Alignment pin (asynchronous, active high) |
| align_en_i | input | 1 | Enables the alignment pin |
| port_code_i | input | 32 | Four 8-bit port codes; port n in bits [8n+7:8n] |
| port_o | output | 4 | Port outputs; bit n is port n |

## Verification
A change on the timing input or on the alignment pin passes through two synchronizer flops and an edge flop before it reaches the timebase. The new count then appears at the ports one flop later, so each step boundary lands about three to six system cycles after the nominal instant. The bench therefore does not sample near a boundary. It queues the expected port vector for each step and compares it half a step after that step's nominal start. It changes codes three quarters of the way through a step, so each change lands well before the next load point. This scheme also checks the divide ratio: with a timing input that toggles every cycle (64-cycle steps) or every second cycle (128-cycle steps), a wrong divider or a wrong source selection moves the windows and makes later samples disagree.

// File: rtl/pwm_stagger_pkg.sv
package pwm_stagger_pkg;

    // Per-port output state machine
    typedef enum logic [1:0] {
        CH_LOW  = 2'd0,
        CH_PWM  = 2'd1,
        CH_HIGH = 2'd2
    } ch_state_e;

    // Upper-nibble code that forces a port high
    localparam logic [3:0] FORCE_HI_NIB = 4'b0111;

endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_int_i,
    input  logic osc_ext_i,
    input  logic use_ext_i,
    input  logic align_pin_i,
    input  logic align_en_i,
    output logic tick_o,
    output logic clr_o
);

    localparam int NSRC = 2;

    logic [NSRC:0]   s_q;
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] rise;

    pwm_sync #(.W(NSRC + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({align_pin_i, osc_ext_i, osc_int_i}),
        .q_o   (s_q)
    );

    // One edge detector per timing source, so switching the select
    // never fabricates an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= s_q[NSRC-1:0];
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_edge
        assign rise[k] = s_q[k] & ~prev_q[k];
    end

    assign tick_o = use_ext_i ? rise[1] : rise[0];
    assign clr_o  = s_q[NSRC] & align_en_i;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int PRE_W = 5,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          clr_i,
    output logic [CW-1:0] count_o,
    output logic          step_o
);

    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            count_o <= '0;
            step_o  <= 1'b0;
        end else if (clr_i) begin
            pre_q   <= '0;
            count_o <= '0;
            step_o  <= 1'b0;
        end else begin
            step_o <= 1'b0;
            if (tick_i) begin
                if (pre_q == PRE_MAX) begin
                    pre_q   <= '0;
                    count_o <= count_o + 1'b1;
                    step_o  <= 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pwm_port_ch.sv
module pwm_port_ch
    import pwm_stagger_pkg::*;
#(
    parameter int CW     = 5,
    parameter int CODE_W = 8,
    parameter int PHASE  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CW-1:0]     count_i,
    input  logic              step_i,
    input  logic              clr_i,
    output logic              port_o,
    output logic              load_o,
    output logic              hi_o,
    output logic              lo_o,
    output logic [CW+1:0]     cfg_o
);

    localparam logic [CW-1:0] PH = CW'(PHASE);

    ch_state_e    st_q, st_nx, st_dec;
    logic [CW-1:0] duty_q, duty_nx, duty_dec, rel;
    logic          load;

    always_comb begin
        rel      = count_i - PH;
        load     = clr_i || (step_i && rel == '0);
        duty_dec = code_i[CW-1:0];
        if (code_i[CODE_W-1 -: 4] == FORCE_HI_NIB) st_dec = CH_HIGH;
        else if (duty_dec == '0)                   st_dec = CH_LOW;
        else                                       st_dec = CH_PWM;
        st_nx   = load ? st_dec   : st_q;
        duty_nx = load ? duty_dec : duty_q;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CH_LOW;
            duty_q <= '0;
        end else begin
            st_q   <= st_nx;
            duty_q <= duty_nx;
        end
    end

    // Output register, driven from the next state so a load never
    // shows one cycle of the previous setting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_o <= 1'b0;
        end else begin
            unique case (st_nx)
                CH_LOW:  port_o <= 1'b0;
                CH_HIGH: port_o <= 1'b1;
                CH_PWM:  port_o <= (rel < duty_nx);
                default: port_o <= 1'b0;
            endcase
        end
    end

    assign load_o = load;
    assign hi_o   = (st_q == CH_HIGH);
    assign lo_o   = (st_q == CH_LOW);
    assign cfg_o  = {st_q, duty_q};

endmodule

// File: rtl/pwm_stagger_top.sv
module pwm_stagger_top #(
    parameter int NPORT       = 4,
    parameter int CW          = 5,
    parameter int PRE_W       = 5,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    osc_int_i,
    input  logic                    osc_ext_i,
    input  logic                    use_ext_i,
    input  logic                    align_pin_i,
    input  logic                    align_en_i,
    input  logic [NPORT*CODE_W-1:0] port_code_i,
    output logic [NPORT-1:0]        port_o
);

    localparam int PERIOD  = 1 << CW;
    localparam int STAGGER = PERIOD / 8;
    localparam int CFG_W   = CW + 2;

    logic                   tick;
    logic                   clr;
    logic                   step;
    logic [CW-1:0]          count;
    logic [NPORT-1:0]       ch_load;
    logic [NPORT-1:0]       ch_hi;
    logic [NPORT-1:0]       ch_lo;
    logic [NPORT*CFG_W-1:0] ch_cfg;

    pwm_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_int_i   (osc_int_i),
        .osc_ext_i   (osc_ext_i),
        .use_ext_i   (use_ext_i),
        .align_pin_i (align_pin_i),
        .align_en_i  (align_en_i),
        .tick_o      (tick),
        .clr_o       (clr)
    );

    pwm_timebase #(.PRE_W(PRE_W), .CW(CW)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .clr_i   (clr),
        .count_o (count),
        .step_o  (step)
    );

    for (genvar n = 0; n < NPORT; n++) begin : g_ch
        pwm_port_ch #(
            .CW     (CW),
            .CODE_W (CODE_W),
            .PHASE  ((n * STAGGER) % PERIOD)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .code_i  (port_code_i[n*CODE_W +: CODE_W]),
            .count_i (count),
            .step_i  (step),
            .clr_i   (clr),
            .port_o  (port_o[n]),
            .load_o  (ch_load[n]),
            .hi_o    (ch_hi[n]),
            .lo_o    (ch_lo[n]),
            .cfg_o   (ch_cfg[n*CFG_W +: CFG_W])
        );
    end

endmodule

// File: rtl/pwm_stagger_chk.sv
module pwm_stagger_chk #(
    parameter int NPORT = 4,
    parameter int CW    = 5,
    parameter int PRE_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input logic                    clr,
    input logic                    step,
    input logic [CW-1:0]           count,
    input logic [NPORT-1:0]        port_o,
    input logic [NPORT-1:0]        ch_load,
    input logic [NPORT-1:0]        ch_hi,
    input logic [NPORT-1:0]        ch_lo,
    input logic [NPORT*(CW+2)-1:0] ch_cfg
);

    localparam int              PERIOD  = 1 << CW;
    localparam int              STAGGER = PERIOD / 8;
    localparam int              CFG_W   = CW + 2;
    localparam logic [PRE_W:0]  FULL    = (PRE_W+1)'(1 << PRE_W);

    // Timing edges seen since the last step or clear
    logic [PRE_W:0] tcnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tcnt <= '0;
        else if (clr)  tcnt <= '0;
        else if (step) tcnt <= (PRE_W+1)'(tick);
        else if (tick) tcnt <= tcnt + 1'b1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_out_low_in_reset_R1: assert (port_o == '0)
                else $error("port_o not low during reset");
        end
    end

    assert_step_after_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> tcnt == FULL)
        else $error("step without 32 timing edges");

    assert_count_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> count == CW'($past(count) + 1'b1))
        else $error("count did not advance by one");

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !step))
        else $error("clear did not hold timebase at zero");

    for (genvar n = 0; n < NPORT; n++) begin : g_port
        localparam logic [CW-1:0] PH = CW'((n * STAGGER) % PERIOD);

        assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_lo[n] && !ch_load[n]) |=> !port_o[n])
            else $error("low-state port went high");

        assert_forced_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_hi[n] && !ch_load[n]) |=> port_o[n])
            else $error("forced-high port went low");

        assert_rise_at_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_o[n]) |-> (count == PH || $past(clr) || $past(clr, 2)))
            else $error("port rose outside its own phase");

        assert_load_at_own_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ch_cfg[n*CFG_W +: CFG_W]) |-> ($past(clr) || ($past(step) && count == PH)))
            else $error("port setting changed away from its period start");
    end

endmodule

bind pwm_stagger_top pwm_stagger_chk #(
    .NPORT (NPORT),
    .CW    (CW),
    .PRE_W (PRE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clr     (clr),
    .step    (step),
    .count   (count),
    .port_o  (port_o),
    .ch_load (ch_load),
    .ch_hi   (ch_hi),
    .ch_lo   (ch_lo),
    .ch_cfg  (ch_cfg)
);

// File: tb/sim_pwm_stagger_top.sv
module sim_pwm_stagger_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;

    typedef struct {
        longint     cyc;
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_int = 1'b0;
    logic        osc_ext = 1'b0;
    logic        use_ext = 1'b0;
    logic        align_pin = 1'b1;
    logic        align_en = 1'b1;
    logic [7:0]  code [NP];
    logic [7:0]  lat  [NP];
    logic [31:0] port_code;
    logic [3:0]  port_o;

    longint cyc = 0;
    longint t0 = 0;
    int     step_len = 64;
    int     n_checks = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    item_t  sb [$];

    assign port_code = {code[3], code[2], code[1], code[0]};

    pwm_stagger_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_int_i   (osc_int),
        .osc_ext_i   (osc_ext),
        .use_ext_i   (use_ext),
        .align_pin_i (align_pin),
        .align_en_i  (align_en),
        .port_code_i (port_code),
        .port_o      (port_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Internal source toggles every cycle, external every second cycle
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            k++;
            osc_int = ~osc_int;
            if (k % 2 == 0) osc_ext = ~osc_ext;
        end
    end

    function automatic logic exp_bit(input logic [7:0] c, input int cnt, input int n);
        int rel;
        if (c[7:4] == 4'b0111) return 1'b1;
        rel = (cnt - 4*n + 32) % 32;
        return (rel < int'(c[4:0]));
    endfunction

    function automatic logic [3:0] exp_vec(input int cnt);
        logic [3:0] v;
        for (int n = 0; n < NP; n++) v[n] = exp_bit(lat[n], cnt, n);
        return v;
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        n_checks++;
        if (port_o !== exp) begin
            n_fail++;
            $display("FAIL %s: port_o=%b expected %b (cycle %0d)", tag, port_o, exp, cyc);
        end
    endtask

    // Driver: model each step and queue its expected port vector
    task automatic run_steps(input int s_first, input int s_last, input string tag);
        for (int s = s_first; s <= s_last; s++) begin
            int    cnt;
            item_t it;
            cnt = s % 32;
            if (s > 0) begin
                for (int n = 0; n < NP; n++) if (cnt == 4*n) lat[n] = code[n];
            end
            it.cyc = t0 + longint'(step_len) * s + step_len / 2;
            it.exp = exp_vec(cnt);
            it.tag = tag;
            sb.push_back(it);
            while (cyc < t0 + longint'(step_len) * s + (3 * step_len) / 4) @(negedge clk);
        end
    endtask

    task automatic set_codes(input logic [7:0] c0, input logic [7:0] c1,
                             input logic [7:0] c2, input logic [7:0] c3);
        code[0] = c0; code[1] = c1; code[2] = c2; code[3] = c3;
    endtask

    // Monitor: compare queued items at their sample cycle
    initial forever begin
        @(negedge clk);
        if (sb.size() > 0 && sb[0].cyc == cyc) begin
            item_t it;
            it = sb.pop_front();
            check(it.exp, it.tag);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        set_codes(8'h08, 8'h10, 8'h00, 8'h70);
        repeat (5) @(negedge clk);
        check(4'b0000, "R1 outputs low in reset");
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        // Clear held: count 0; port0 duty 8 high, port1 rel 28 low, port2 zero, port3 forced
        check(4'b1001, "R9 load during clear");
        for (int n = 0; n < NP; n++) lat[n] = code[n];

        // Phase A: internal source, 64-cycle steps
        align_pin = 1'b0;
        t0 = cyc;
        step_len = 64;
        run_steps(0, 35, "R2 R3 R4 R5 R6");
        set_codes(8'h1F, 8'h75, 8'h81, 8'h04);
        run_steps(36, 70, "R7 R11 R3");

        // Phase B: external source, realign, 128-cycle steps
        use_ext = 1'b1;
        align_pin = 1'b1;
        set_codes(8'h03, 8'h00, 8'h7A, 8'h1E);
        repeat (10) @(negedge clk);
        check(4'b1101, "R9 hold after realign");
        for (int n = 0; n < NP; n++) lat[n] = code[n];
        align_pin = 1'b0;
        t0 = cyc;
        step_len = 128;
        run_steps(0, 10, "R8 R9");
        align_en = 1'b0;
        align_pin = 1'b1;
        repeat (5) @(negedge clk);
        align_pin = 1'b0;
        run_steps(11, 40, "R10 R8");

        while (sb.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule